// File: doc/BRIEF.md
# Keypad Lock Command Sequencer

This block is the control core of a keypad-operated lock. A debounced keypad front end hands it one key code per strobe. The sequencer reads framing keys out of that stream. The key 9 opens and closes a lock/unlock command that carries the user code. The key 8 opens a reprogram command and separates its fields: the programming code, then the new user code entered twice. The sequencer holds the locked/unlocked state and drives a lock-status LED. It also drives an indicator LED that plays a slow three-blink pattern on any error and a fast five-blink pattern when a reprogram succeeds.

The codes themselves are stored and compared outside this block, by a passcode verifier. The sequencer streams the entered digits to the verifier and tags each field. When a field closes, it asks for a verdict and then acts on the answer. If a partial command sees no key press for a programmable number of cycles, the command is dropped without comment.

Top module: `keypad_lock_seq`

## Requirements
- R1: After reset the lock is closed (`lock_led` = 1), `ind_led` is 0 and no verifier strobe is raised.
- R2: While idle, a key of 9 starts a user-code field. The next key of 9 closes it. If the verifier accepts the field, `lock_led` inverts one cycle after the verdict. If it rejects the field, the error pattern plays and `lock_led` keeps its value.
- R3: Verifier handshake. `vfy_start` pulses for one cycle to open a field. `vfy_digit_valid` with `vfy_digit` forwards each data key. `vfy_check` pulses for one cycle to close a field, and `vfy_ok` is read during that cycle. `vfy_field` tags every strobe: 0 user code, 1 programming code, 2 first new code, 3 second new code. No two of start, digit, check and commit are raised in the same cycle.
- R4: While idle, a key of 8 starts a reprogram. Each 8 closes the current field in the order 1, 2, 3. An accepted field opens the next one. An accepted field 3 raises `vfy_commit` for one cycle and starts the success pattern. `lock_led` is untouched.
- R5: A rejected field of any kind aborts the command and plays the error pattern: 3 pulses of `ind_led`, each high for 4·FAST_HALF cycles and low for 4·FAST_HALF cycles.
- R6: The success pattern is 5 pulses, each high for FAST_HALF cycles and low for FAST_HALF cycles.
- R7: While a pattern plays, every key is ignored: nothing is forwarded and no field opens. The sequencer is idle again once the pattern ends.
- R8: In an open field, the command is abandoned when IDLE_TIMEOUT cycles pass without a key. When that happens there is no blink, no check and no change of lock state. A key arriving exactly IDLE_TIMEOUT cycles after the previous one is still taken.
- R9: While idle, every key other than 8 and 9 is ignored. Key codes 10 to 15 are ignored in every state.
- R10: After a committed reprogram, lock/unlock commands are judged against the new user code (verifier behaviour exercised end to end).
- R11: Inside a user-code field, 8 is forwarded as a data digit. Inside a reprogram field, 9 is forwarded as a data digit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_valid | input | 1 | One-cycle key strobe |
| key_digit | input | 4 | Key code; 0-9 valid |
| vfy_ok | input | 1 | Verifier verdict, read while `vfy_check` is high |
| vfy_start | output | 1 | Open a new field in the verifier |
| vfy_field | output | 2 | Field tag for all verifier strobes |
| vfy_digit_valid | output | 1 | Data digit strobe |
| vfy_digit | output | 4 | Data digit |
| vfy_check | output | 1 | Close field and request verdict |
| vfy_commit | output | 1 | Store first new code as user code |
| lock_led | output | 1 | 1 while locked |
| ind_led | output | 1 | Error / success blink indicator |

## Verification
Two functions can fall due in the same cycle, and the bench provokes both. The first pair is the idle timeout and a key strobe. The bench spaces the final key exactly IDLE_TIMEOUT cycles after its predecessor, so expiry and the key meet on one edge; the key must win and the lock must toggle. One cycle more must abandon the command, which is judged by the missing check and the unchanged lock LED. The second pair is the blink playback and keypad input. The bench presses 9 in the middle of a pattern and then counts verifier strobes to confirm that no field opened.

// File: rtl/klk_pkg.sv
package klk_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_USER,
    S_PROG,
    S_NEWA,
    S_NEWB,
    S_CHK,
    S_BLINK
  } ctl_state_e;

  typedef enum logic [1:0] {
    FLD_USER = 2'd0,
    FLD_PROG = 2'd1,
    FLD_NEWA = 2'd2,
    FLD_NEWB = 2'd3
  } code_field_e;

  localparam logic [3:0] KEY_LOCK = 4'd9;
  localparam logic [3:0] KEY_PROG = 4'd8;
  localparam logic [3:0] KEY_MAX  = 4'd9;

endpackage

// File: rtl/klk_blinker.sv
module klk_blinker #(
  parameter int FAST_HALF = 4,
  parameter int SLOW_MULT = 4,
  parameter int ERR_COUNT = 3,
  parameter int OK_COUNT  = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic kind_ok,
  output logic led,
  output logic done
);
  localparam int SLOW_HALF = FAST_HALF * SLOW_MULT;
  localparam int CW        = $clog2(SLOW_HALF + 1);
  localparam int NMAX      = (ERR_COUNT > OK_COUNT) ? ERR_COUNT : OK_COUNT;
  localparam int NW        = $clog2(NMAX + 1);

  logic          active_q, active_n;
  logic          led_q, led_n;
  logic          fast_q, fast_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [NW-1:0] left_q, left_n;
  logic          half_end;

  assign half_end = fast_q ? (cnt_q == CW'(FAST_HALF - 1))
                           : (cnt_q == CW'(SLOW_HALF - 1));

  always_comb begin
    active_n = active_q;
    led_n    = led_q;
    fast_n   = fast_q;
    cnt_n    = cnt_q;
    left_n   = left_q;
    if (go) begin
      active_n = 1'b1;
      led_n    = 1'b1;
      cnt_n    = '0;
      fast_n   = kind_ok;
      left_n   = kind_ok ? NW'(OK_COUNT) : NW'(ERR_COUNT);
    end else if (active_q) begin
      if (half_end) begin
        cnt_n = '0;
        if (led_q) begin
          led_n = 1'b0;
        end else if (left_q == NW'(1)) begin
          active_n = 1'b0;
        end else begin
          left_n = left_q - NW'(1);
          led_n  = 1'b1;
        end
      end else begin
        cnt_n = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      led_q    <= 1'b0;
      fast_q   <= 1'b0;
      cnt_q    <= '0;
      left_q   <= '0;
    end else begin
      active_q <= active_n;
      led_q    <= led_n;
      fast_q   <= fast_n;
      cnt_q    <= cnt_n;
      left_q   <= left_n;
    end
  end

  assign led  = led_q;
  assign done = active_q && half_end && !led_q && (left_q == NW'(1));

endmodule

// File: rtl/klk_idle_timer.sv
module klk_idle_timer #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic kick,
  output logic expire
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q, cnt_n;
  logic          at_limit;

  assign at_limit = (cnt_q == CW'(LIMIT - 1));
  assign expire   = run && !kick && at_limit;

  always_comb begin
    if (!run || kick) begin
      cnt_n = '0;
    end else if (!at_limit) begin
      cnt_n = cnt_q + CW'(1);
    end else begin
      cnt_n = cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

endmodule

// File: rtl/klk_ctrl.sv
module klk_ctrl
  import klk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_valid,
  input  logic [3:0] key_digit,
  input  logic       vfy_ok,
  input  logic       tmo_expire,
  input  logic       blink_done,
  output logic       in_entry,
  output logic       blink_go,
  output logic       blink_ok,
  output logic       vfy_start,
  output logic [1:0] vfy_field,
  output logic       vfy_digit_valid,
  output logic [3:0] vfy_digit,
  output logic       vfy_check,
  output logic       vfy_commit,
  output logic       lock_led
);
  ctl_state_e  state_q, state_n;
  code_field_e field_q, field_n;
  logic        lock_q, lock_n;
  logic        start_q, start_n;
  logic        dval_q, dval_n;
  logic [3:0]  digit_q, digit_n;
  logic        check_q, check_n;
  logic        commit_q, commit_n;
  logic        key_ok;
  logic [3:0]  close_key;

  assign key_ok    = key_valid && (key_digit <= KEY_MAX);
  assign close_key = (state_q == S_USER) ? KEY_LOCK : KEY_PROG;
  assign in_entry  = (state_q == S_USER) || (state_q == S_PROG) ||
                     (state_q == S_NEWA) || (state_q == S_NEWB);

  always_comb begin
    state_n  = state_q;
    field_n  = field_q;
    lock_n   = lock_q;
    start_n  = 1'b0;
    dval_n   = 1'b0;
    digit_n  = digit_q;
    check_n  = 1'b0;
    commit_n = 1'b0;
    blink_go = 1'b0;
    blink_ok = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (key_ok && key_digit == KEY_LOCK) begin
          state_n = S_USER;
          field_n = FLD_USER;
          start_n = 1'b1;
        end else if (key_ok && key_digit == KEY_PROG) begin
          state_n = S_PROG;
          field_n = FLD_PROG;
          start_n = 1'b1;
        end
      end
      S_USER, S_PROG, S_NEWA, S_NEWB: begin
        if (key_ok) begin
          if (key_digit == close_key) begin
            state_n = S_CHK;
            check_n = 1'b1;
          end else begin
            dval_n  = 1'b1;
            digit_n = key_digit;
          end
        end else if (tmo_expire) begin
          state_n = S_IDLE;
        end
      end
      S_CHK: begin
        if (vfy_ok) begin
          unique case (field_q)
            FLD_USER: begin
              lock_n  = ~lock_q;
              state_n = S_IDLE;
            end
            FLD_PROG: begin
              state_n = S_NEWA;
              field_n = FLD_NEWA;
              start_n = 1'b1;
            end
            FLD_NEWA: begin
              state_n = S_NEWB;
              field_n = FLD_NEWB;
              start_n = 1'b1;
            end
            FLD_NEWB: begin
              commit_n = 1'b1;
              blink_go = 1'b1;
              blink_ok = 1'b1;
              state_n  = S_BLINK;
            end
            default: state_n = S_IDLE;
          endcase
        end else begin
          blink_go = 1'b1;
          state_n  = S_BLINK;
        end
      end
      S_BLINK: begin
        if (blink_done) state_n = S_IDLE;
      end
      default: state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      field_q  <= FLD_USER;
      lock_q   <= 1'b1;
      start_q  <= 1'b0;
      dval_q   <= 1'b0;
      digit_q  <= 4'd0;
      check_q  <= 1'b0;
      commit_q <= 1'b0;
    end else begin
      state_q  <= state_n;
      field_q  <= field_n;
      lock_q   <= lock_n;
      start_q  <= start_n;
      dval_q   <= dval_n;
      check_q  <= check_n;
      commit_q <= commit_n;
      if (dval_n) digit_q <= digit_n;
    end
  end

  assign vfy_start       = start_q;
  assign vfy_field       = field_q;
  assign vfy_digit_valid = dval_q;
  assign vfy_digit       = digit_q;
  assign vfy_check       = check_q;
  assign vfy_commit      = commit_q;
  assign lock_led        = lock_q;

endmodule

// File: rtl/keypad_lock_seq.sv
module keypad_lock_seq #(
  parameter int FAST_HALF    = 6_250_000,
  parameter int SLOW_MULT    = 4,
  parameter int ERR_COUNT    = 3,
  parameter int OK_COUNT     = 5,
  parameter int IDLE_TIMEOUT = 250_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_valid,
  input  logic [3:0] key_digit,
  input  logic       vfy_ok,
  output logic       vfy_start,
  output logic [1:0] vfy_field,
  output logic       vfy_digit_valid,
  output logic [3:0] vfy_digit,
  output logic       vfy_check,
  output logic       vfy_commit,
  output logic       lock_led,
  output logic       ind_led
);
  logic in_entry;
  logic tmo_expire;
  logic blink_go;
  logic blink_ok;
  logic blink_done;

  klk_ctrl u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .key_valid      (key_valid),
    .key_digit      (key_digit),
    .vfy_ok         (vfy_ok),
    .tmo_expire     (tmo_expire),
    .blink_done     (blink_done),
    .in_entry       (in_entry),
    .blink_go       (blink_go),
    .blink_ok       (blink_ok),
    .vfy_start      (vfy_start),
    .vfy_field      (vfy_field),
    .vfy_digit_valid(vfy_digit_valid),
    .vfy_digit      (vfy_digit),
    .vfy_check      (vfy_check),
    .vfy_commit     (vfy_commit),
    .lock_led       (lock_led)
  );

  klk_idle_timer #(
    .LIMIT(IDLE_TIMEOUT)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (in_entry),
    .kick  (key_valid),
    .expire(tmo_expire)
  );

  klk_blinker #(
    .FAST_HALF(FAST_HALF),
    .SLOW_MULT(SLOW_MULT),
    .ERR_COUNT(ERR_COUNT),
    .OK_COUNT (OK_COUNT)
  ) u_blink (
    .clk    (clk),
    .rst_n  (rst_n),
    .go     (blink_go),
    .kind_ok(blink_ok),
    .led    (ind_led),
    .done   (blink_done)
  );

endmodule

// File: rtl/klk_lock_checker.sv
module klk_lock_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       vfy_start,
  input logic [1:0] vfy_field,
  input logic       vfy_digit_valid,
  input logic       vfy_check,
  input logic       vfy_ok,
  input logic       vfy_commit,
  input logic       lock_led,
  input logic       ind_led
);
  // R2: lock state moves only after an accepted user-code field
  a_r2_lock_moves_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_led != $past(lock_led)) |-> $past(vfy_check && vfy_ok && vfy_field == 2'd0));

  // R4: commit only after an accepted second new-code field
  a_r4_commit_after_match: assert property (@(posedge clk) disable iff (!rst_n)
    vfy_commit |-> $past(vfy_check && vfy_ok && vfy_field == 2'd3));

  // R3: at most one verifier strobe per cycle
  a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({vfy_start, vfy_digit_valid, vfy_check, vfy_commit}));

  // R3: check is a single-cycle pulse
  a_r3_check_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    vfy_check |=> !vfy_check);

  // R7: nothing forwarded while the indicator is lit
  a_r7_quiet_while_lit: assert property (@(posedge clk) disable iff (!rst_n)
    ind_led |-> !vfy_digit_valid && !vfy_start);
endmodule

bind keypad_lock_seq klk_lock_checker u_klk_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .vfy_start      (vfy_start),
  .vfy_field      (vfy_field),
  .vfy_digit_valid(vfy_digit_valid),
  .vfy_check      (vfy_check),
  .vfy_ok         (vfy_ok),
  .vfy_commit     (vfy_commit),
  .lock_led       (lock_led),
  .ind_led        (ind_led)
);

// File: tb/tb_keypad_lock_seq.sv
`timescale 1ns/1ps
module tb_keypad_lock_seq;
  localparam int HALF  = 2;
  localparam int MULT  = 4;
  localparam int LIMIT = 20;
  localparam logic [31:0] PCODE = 32'h455612;

  logic       clk, rst_n, key_valid, vfy_ok;
  logic [3:0] key_digit;
  logic       vfy_start, vfy_digit_valid, vfy_check, vfy_commit, lock_led, ind_led;
  logic [1:0] vfy_field;
  logic [3:0] vfy_digit;

  keypad_lock_seq #(.FAST_HALF(HALF), .SLOW_MULT(MULT), .ERR_COUNT(3), .OK_COUNT(5),
                    .IDLE_TIMEOUT(LIMIT)) dut (
    .clk(clk), .rst_n(rst_n), .key_valid(key_valid), .key_digit(key_digit),
    .vfy_ok(vfy_ok), .vfy_start(vfy_start), .vfy_field(vfy_field),
    .vfy_digit_valid(vfy_digit_valid), .vfy_digit(vfy_digit), .vfy_check(vfy_check),
    .vfy_commit(vfy_commit), .lock_led(lock_led), .ind_led(ind_led));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // verifier model
  logic [31:0] m_buf, m_uc, m_a;
  logic [3:0]  m_len, m_uclen, m_alen;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_buf <= '0; m_len <= '0; m_uc <= 32'h666666; m_uclen <= 4'd6;
      m_a <= '0; m_alen <= '0;
    end else begin
      if (vfy_start) begin m_buf <= '0; m_len <= '0; end
      if (vfy_digit_valid) begin m_buf <= {m_buf[27:0], vfy_digit}; m_len <= m_len + 4'd1; end
      if (vfy_check && vfy_field == 2'd2) begin m_a <= m_buf; m_alen <= m_len; end
      if (vfy_commit) begin m_uc <= m_a; m_uclen <= m_alen; end
    end
  end
  always_comb begin
    case (vfy_field)
      2'd0:    vfy_ok = (m_buf == m_uc) && (m_len == m_uclen);
      2'd1:    vfy_ok = (m_buf == PCODE) && (m_len == 4'd6);
      2'd2:    vfy_ok = (m_len >= 4'd4) && (m_len <= 4'd6);
      default: vfy_ok = (m_buf == m_a) && (m_len == m_alen);
    endcase
  end

  // monitor
  int n_start, n_dig, n_chk, n_commit, n_rise, n_high;
  logic prev_ind;
  always @(negedge clk) begin
    if (!rst_n) begin
      n_start = 0; n_dig = 0; n_chk = 0; n_commit = 0; n_rise = 0; n_high = 0; prev_ind = 1'b0;
    end else begin
      if (vfy_start) n_start++;
      if (vfy_digit_valid) n_dig++;
      if (vfy_check) n_chk++;
      if (vfy_commit) n_commit++;
      if (ind_led && !prev_ind) n_rise++;
      if (ind_led) n_high++;
      prev_ind = ind_led;
    end
  end

  int checks = 0, errors = 0;
  int s_start, s_dig, s_chk, s_commit, s_rise, s_high;
  logic exp_lock;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic snap();
    s_start = n_start; s_dig = n_dig; s_chk = n_chk;
    s_commit = n_commit; s_rise = n_rise; s_high = n_high;
  endtask

  task automatic press(input logic [3:0] d);
    @(negedge clk); key_valid = 1'b1; key_digit = d;
    @(negedge clk); key_valid = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send(input logic [31:0] code, input int len);
    for (int i = len - 1; i >= 0; i--) press(code[i*4 +: 4]);
  endtask

  task automatic pattern(input string tag, input int pulses, input int half);
    repeat (60) @(negedge clk);
    chk(n_rise - s_rise == pulses, {tag, " pulses"}, n_rise - s_rise, pulses);
    chk(n_high - s_high == pulses * half, {tag, " high cycles"}, n_high - s_high, pulses * half);
    chk(ind_led == 1'b0, {tag, " led off after"}, ind_led, 0);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; key_valid = 1'b0; key_digit = 4'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    exp_lock = 1'b1;
    // R1
    chk(lock_led == 1'b1, "R1 lock at reset", lock_led, 1);
    chk(ind_led == 1'b0, "R1 ind at reset", ind_led, 0);
    chk(n_start + n_dig + n_chk + n_commit == 0, "R1 no strobes", n_start + n_dig + n_chk + n_commit, 0);

    // R9: idle sweep over all codes except 8 and 9
    snap();
    for (int d = 0; d < 16; d++) if (d != 8 && d != 9) press(4'(d));
    chk(n_start == s_start && n_dig == s_dig, "R9 idle keys ignored", n_start - s_start + n_dig - s_dig, 0);

    // R2/R3: correct code toggles twice
    for (int k = 0; k < 2; k++) begin
      snap();
      press(4'd9); press(4'd14); send(32'h666666, 6); press(4'd9);
      exp_lock = ~exp_lock;
      chk(lock_led == exp_lock, "R2 toggle", lock_led, exp_lock);
      chk(n_dig - s_dig == 6 && n_chk - s_chk == 1 && n_start - s_start == 1,
          "R3 strobe counts", n_dig - s_dig, 6);
      chk(vfy_field == 2'd0, "R3 user field tag", vfy_field, 0);
      chk(n_rise == s_rise, "R2 no blink on toggle", n_rise - s_rise, 0);
    end

    // R2/R5/R7: wrong code, keys during blink ignored
    snap();
    press(4'd9); send(32'h1234, 4); press(4'd9);
    press(4'd9); press(4'd8); press(4'd9);
    pattern("R5 error", 3, HALF * MULT);
    chk(lock_led == exp_lock, "R2 lock kept on error", lock_led, exp_lock);
    chk(n_start == s_start + 1, "R7 keys ignored during blink", n_start - s_start, 1);
    snap();
    press(4'd9);
    chk(n_start == s_start + 1, "R7 idle after pattern", n_start - s_start, 1);
    send(32'h666666, 6); press(4'd9);
    exp_lock = ~exp_lock;
    chk(lock_led == exp_lock, "R7 command after pattern", lock_led, exp_lock);

    // R11: 8 is data in user field
    snap();
    press(4'd9); press(4'd1); press(4'd8); press(4'd2);
    chk(n_dig - s_dig == 3 && n_chk == s_chk, "R11 8 as data", n_dig - s_dig, 3);
    press(4'd9);
    pattern("R11 error", 3, HALF * MULT);

    // R4/R6: successful reprogram
    snap();
    press(4'd8); send(PCODE, 6); press(4'd8); send(32'h1357, 4); press(4'd8);
    send(32'h1357, 4); press(4'd8);
    pattern("R6 success", 5, HALF);
    chk(n_commit - s_commit == 1, "R4 commit", n_commit - s_commit, 1);
    chk(n_start - s_start == 3 && n_chk - s_chk == 3, "R4 fields", n_start - s_start, 3);
    chk(lock_led == exp_lock, "R4 lock untouched", lock_led, exp_lock);

    // R10: old code rejected, new accepted
    snap();
    press(4'd9); send(32'h666666, 6); press(4'd9);
    pattern("R10 old code", 3, HALF * MULT);
    press(4'd9); send(32'h1357, 4); press(4'd9);
    exp_lock = ~exp_lock;
    chk(lock_led == exp_lock, "R10 new code", lock_led, exp_lock);

    // R5: wrong programming code
    snap();
    press(4'd8); send(32'h123456, 6); press(4'd8);
    pattern("R5 bad prog", 3, HALF * MULT);
    chk(n_chk - s_chk == 1, "R5 aborted after prog", n_chk - s_chk, 1);

    // R5: mismatch of second entry, R11 9 as data
    snap();
    press(4'd8); send(PCODE, 6); press(4'd8); press(4'd2); press(4'd9);
    chk(n_chk - s_chk == 1, "R11 9 as data", n_chk - s_chk, 1);
    send(32'h46, 2); press(4'd8); send(32'h2947, 4); press(4'd8);
    pattern("R5 mismatch", 3, HALF * MULT);
    chk(n_commit == s_commit, "R5 no commit", n_commit - s_commit, 0);

    // R5: too short new code
    snap();
    press(4'd8); send(PCODE, 6); press(4'd8); send(32'h12, 2); press(4'd8);
    pattern("R5 short", 3, HALF * MULT);

    // R8: gap of LIMIT+1 abandons
    snap();
    press(4'd9); send(32'h135, 3);
    repeat (LIMIT - 3) @(negedge clk);
    press(4'd7); press(4'd9);
    repeat (LIMIT + 4) @(negedge clk);
    chk(n_chk == s_chk, "R8 timeout no check", n_chk - s_chk, 0);
    chk(lock_led == exp_lock, "R8 timeout lock kept", lock_led, exp_lock);
    chk(n_rise == s_rise, "R8 timeout no blink", n_rise - s_rise, 0);
    chk(n_start - s_start == 2, "R8 idle after timeout", n_start - s_start, 2);

    // R8: gap of exactly LIMIT is accepted
    snap();
    press(4'd9); send(32'h135, 3);
    repeat (LIMIT - 4) @(negedge clk);
    press(4'd7); press(4'd9);
    exp_lock = ~exp_lock;
    chk(lock_led == exp_lock, "R8 boundary accepted", lock_led, exp_lock);
    chk(n_rise == s_rise, "R8 boundary no blink", n_rise - s_rise, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule